// File: doc/BRIEF.md
# Core Test Wrapper Cell Array

This block sits between an embedded core and the rest of the chip. Every core terminal can either keep its functional connection to the chip side or be taken over by a serial test access path. A two-bit mode register, loaded by a strobe, chooses one of three modes. In functional mode the wrapper is transparent. In core test mode the core is cut off from its neighbours: its inputs come from update latches loaded through a serial chain, its outputs are captured into that chain and shifted back out, and the chip side sees a safe zero. In bypass mode the serial test data passes through one flip-flop so that neighbouring cores and interconnect can be exercised on a short path.

The wrapper chain adapts widths. Bits shifted in one per clock appear in parallel on the core inputs after an update pulse. Parallel core outputs captured in one clock leave one per clock on the serial output. The chain holds the input cells first and the output cells after them. The core inputs hold their value while shifting is in progress, so the core sees no ripple.

Top module: `core_wrap_top`

## Requirements
- R1: After reset the mode is functional (00), the serial output is 0 and the core-input update latches hold all zeros.
- R2: The mode register loads `modeSel` only on a clock edge where `modeLoad` is high. Its codes are 00 functional, 01 core test, 10 bypass, and 11 also acts as bypass.
- R3: In functional mode `coreIn` equals `chipIn`, `chipOut` equals `coreOut`, and `tamOut` is 0.
- R4: In core test mode, with `shiftEn` high, the chain moves one position per clock. Position 0 takes `tamIn`, position k takes position k-1, and `tamOut` shows the last position. Input terminal i sits at position i, and output terminal j sits at position IN_W+j.
- R5: In core test mode, a clock edge with `captureEn` high and `shiftEn` low loads `coreOut[j]` into chain position IN_W+j.
- R6: In core test mode, a clock edge with `updateEn` high copies chain positions 0..IN_W-1 into the latches that drive `coreIn`. `coreIn` does not change at any other time, including while the chain shifts.
- R7: In core test mode, `coreIn` does not depend on `chipIn`, and `chipOut` is all zeros.
- R8: In bypass mode `tamOut` equals the value `tamIn` had one clock earlier, while `coreIn` follows `chipIn` and `chipOut` follows `coreOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Mode code presented for loading |
| modeLoad | input | 1 | Strobe that loads modeSel into the mode register |
| shiftEn | input | 1 | Shift the wrapper chain by one position |
| captureEn | input | 1 | Capture core outputs into the output cells |
| updateEn | input | 1 | Transfer input cells to the core-input latches |
| tamIn | input | 1 | Serial test data in |
| tamOut | output | 1 | Serial test data out |
| chipIn | input | IN_W | Functional signals from the chip toward the core |
| coreIn | output | IN_W | Signals driving the core inputs |
| coreOut | input | OUT_W | Signals coming from the core outputs |
| chipOut | output | OUT_W | Signals driven toward the chip |

## Verification
The bench sweeps every input pattern of a small wrapper through both the functional and the core-test paths, and compares against a behavioural core model. A chain with its order reversed, or with input and output cells swapped, would return shifted bits in the wrong places. A wrapper that forwarded shifted bits straight to the core would show `coreIn` moving before the update pulse. A leaky isolation would let a change on `chipIn` reach `coreIn`, or a non-zero value reach `chipOut`, during core test. The bypass checks look for a lag of other than one clock, and for code 11 being decoded as something other than bypass.

// File: rtl/wrap_pkg.sv
package wrap_pkg;

  typedef enum logic [1:0] {
    MODE_FUNC    = 2'b00,
    MODE_TEST    = 2'b01,
    MODE_BYP     = 2'b10,
    MODE_BYP_ALT = 2'b11
  } wrapMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic testOn;
    logic bypOn;
    logic doShift;
    logic doCapture;
    logic doUpdate;
  } wrapCtl_t;

endpackage

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
  import wrap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       modeLoad,
  input  logic       shiftEn,
  input  logic       captureEn,
  input  logic       updateEn,
  output wrapCtl_t   ctl
);

  wrapMode_e modeQ;

  always_ff @(posedge clk) begin
    if (!rstN)         modeQ <= MODE_FUNC;
    else if (modeLoad) modeQ <= wrapMode_e'(modeSel);
  end

  always_comb begin
    ctl.testOn    = (modeQ == MODE_TEST);
    ctl.bypOn     = (modeQ == MODE_BYP) || (modeQ == MODE_BYP_ALT);
    ctl.doShift   = ctl.testOn && shiftEn;
    ctl.doCapture = ctl.testOn && captureEn && !shiftEn;
    ctl.doUpdate  = ctl.testOn && updateEn;
  end

endmodule

// File: rtl/wrap_bypass.sv
module wrap_bypass (
  input  logic clk,
  input  logic rstN,
  input  logic bypOn,
  input  logic tamIn,
  output logic bypQ
);

  always_ff @(posedge clk) begin
    if (!rstN)      bypQ <= 1'b0;
    else if (bypOn) bypQ <= tamIn;
  end

endmodule

// File: rtl/wrap_dp.sv
module wrap_dp
  import wrap_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrapCtl_t         ctl,
  input  logic             tamIn,
  input  logic             bypQ,
  input  logic [IN_W-1:0]  chipIn,
  input  logic [OUT_W-1:0] coreOut,
  output logic [IN_W-1:0]  coreIn,
  output logic [OUT_W-1:0] chipOut,
  output logic             tamOut
);

  localparam int CHAIN_LEN = IN_W + OUT_W;

  logic [CHAIN_LEN-1:0] cellQ;
  logic [CHAIN_LEN-1:0] shiftSrc;
  logic [IN_W-1:0]      updQ;

  assign shiftSrc = {cellQ[CHAIN_LEN-2:0], tamIn};

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    if (i < IN_W) begin : g_in
      always_ff @(posedge clk) begin
        if (!rstN)            cellQ[i] <= 1'b0;
        else if (ctl.doShift) cellQ[i] <= shiftSrc[i];
      end
    end else begin : g_out
      always_ff @(posedge clk) begin
        if (!rstN)              cellQ[i] <= 1'b0;
        else if (ctl.doShift)   cellQ[i] <= shiftSrc[i];
        else if (ctl.doCapture) cellQ[i] <= coreOut[i-IN_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             updQ <= '0;
    else if (ctl.doUpdate) updQ <= cellQ[IN_W-1:0];
  end

  always_comb begin
    coreIn  = ctl.testOn ? updQ : chipIn;
    chipOut = ctl.testOn ? '0   : coreOut;
    if (ctl.bypOn)       tamOut = bypQ;
    else if (ctl.testOn) tamOut = cellQ[CHAIN_LEN-1];
    else                 tamOut = 1'b0;
  end

endmodule

// File: rtl/core_wrap_top.sv
module core_wrap_top
  import wrap_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             modeLoad,
  input  logic             shiftEn,
  input  logic             captureEn,
  input  logic             updateEn,
  input  logic             tamIn,
  output logic             tamOut,
  input  logic [IN_W-1:0]  chipIn,
  output logic [IN_W-1:0]  coreIn,
  input  logic [OUT_W-1:0] coreOut,
  output logic [OUT_W-1:0] chipOut
);

  wrapCtl_t ctl;
  logic     bypQ;

  wrap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .modeLoad(modeLoad),
    .shiftEn(shiftEn), .captureEn(captureEn), .updateEn(updateEn), .ctl(ctl)
  );

  wrap_bypass u_byp (
    .clk(clk), .rstN(rstN), .bypOn(ctl.bypOn), .tamIn(tamIn), .bypQ(bypQ)
  );

  wrap_dp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tamIn(tamIn), .bypQ(bypQ),
    .chipIn(chipIn), .coreOut(coreOut), .coreIn(coreIn),
    .chipOut(chipOut), .tamOut(tamOut)
  );

endmodule

// File: rtl/wrap_checks.sv
module wrap_checks #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic             modeLoad,
  input logic             shiftEn,
  input logic             captureEn,
  input logic             updateEn,
  input logic             tamIn,
  input logic             tamOut,
  input logic [IN_W-1:0]  chipIn,
  input logic [IN_W-1:0]  coreIn,
  input logic [OUT_W-1:0] coreOut,
  input logic [OUT_W-1:0] chipOut
);

  logic [1:0] trackMode;
  logic       inTest, inByp, inNorm;

  always_ff @(posedge clk) begin
    if (!rstN)         trackMode <= 2'b00;
    else if (modeLoad) trackMode <= modeSel;
  end

  assign inTest = (trackMode == 2'b01);
  assign inByp  = trackMode[1];
  assign inNorm = (trackMode == 2'b00);

  assert_transparent_R3: assert property (@(posedge clk) disable iff (!rstN)
    inNorm |-> (coreIn == chipIn) && (chipOut == coreOut) && !tamOut);

  assert_hold_core_in_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inTest && !updateEn && !modeLoad) |=> $stable(coreIn));

  assert_safe_outputs_R7: assert property (@(posedge clk) disable iff (!rstN)
    inTest |-> (chipOut == '0));

  assert_bypass_lag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inByp && !modeLoad) |=> (tamOut == $past(tamIn)));

  // unused-in-properties inputs folded into a trivial sink
  logic unusedSink;
  assign unusedSink = shiftEn ^ captureEn;

endmodule

bind core_wrap_top wrap_checks #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/test_core_wrap_top.sv
module test_core_wrap_top;

  localparam int IN_W  = 4;
  localparam int OUT_W = 3;
  localparam int CH    = IN_W + OUT_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rstN, modeLoad, shiftEn, captureEn, updateEn, tamIn, tamOut;
  logic [1:0]       modeSel;
  logic [IN_W-1:0]  chipIn, coreIn;
  logic [OUT_W-1:0] coreOut, chipOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [OUT_W-1:0] coreModel(logic [IN_W-1:0] a);
    return {a[3] | a[2], a[1] & a[0], ^a};
  endfunction

  assign coreOut = coreModel(coreIn);

  core_wrap_top #(.IN_W(IN_W), .OUT_W(OUT_W)) i_core_wrap_top (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .modeLoad(modeLoad),
    .shiftEn(shiftEn), .captureEn(captureEn), .updateEn(updateEn),
    .tamIn(tamIn), .tamOut(tamOut), .chipIn(chipIn), .coreIn(coreIn),
    .coreOut(coreOut), .chipOut(chipOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setMode(logic [1:0] m);
    modeSel = m; modeLoad = 1'b1;
    @(negedge clk);
    modeLoad = 1'b0;
  endtask

  task automatic pulseUpdate();
    updateEn = 1'b1; @(negedge clk); updateEn = 1'b0;
  endtask

  task automatic pulseCapture();
    captureEn = 1'b1; @(negedge clk); captureEn = 1'b0;
  endtask

  task automatic shiftAll(input logic [CH-1:0] vin, output logic [CH-1:0] vout);
    shiftEn = 1'b1;
    for (int s = 0; s < CH; s++) begin
      vout[CH-1-s] = tamOut;
      tamIn = vin[CH-1-s];
      @(negedge clk);
    end
    shiftEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CH-1:0] outv;
    logic [IN_W-1:0] prevV;
    rstN = 1'b0; modeSel = 2'b00; modeLoad = 1'b0; shiftEn = 1'b0;
    captureEn = 1'b0; updateEn = 1'b0; tamIn = 1'b0; chipIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chipIn = 4'hA; #1;
    check("R1 tamOut", 32'(tamOut), 0);
    check("R1 functional after reset", 32'(coreIn), 32'hA);

    // R2: no load without strobe
    modeSel = 2'b01; @(negedge clk);
    check("R2 no load without strobe", 32'(chipOut), 32'(coreModel(4'hA)));

    // R1: update latches reset to zero
    setMode(2'b01);
    check("R1 update latch reset", 32'(coreIn), 0);

    // R3: functional sweep
    setMode(2'b00);
    for (int v = 0; v < 16; v++) begin
      chipIn = v[IN_W-1:0]; #1;
      check("R3 coreIn", 32'(coreIn), 32'(v));
      check("R3 chipOut", 32'(chipOut), 32'(coreModel(v[IN_W-1:0])));
      check("R3 tamOut", 32'(tamOut), 0);
      @(negedge clk);
    end

    // R4: chain order round trip
    setMode(2'b01);
    shiftAll(7'h53, outv);
    shiftAll(7'h00, outv);
    check("R4 chain round trip", 32'(outv), 32'h53);

    // R5 R6 R7: core test sweep
    prevV = '0;
    pulseUpdate();
    for (int v = 0; v < 16; v++) begin
      chipIn = v[IN_W-1:0];
      shiftAll({3'b000, v[IN_W-1:0]}, outv);
      check("R6 coreIn held during shift", 32'(coreIn), 32'(prevV));
      pulseUpdate();
      check("R6 coreIn after update", 32'(coreIn), 32'(v));
      chipIn = ~v[IN_W-1:0]; #1;
      check("R7 isolation coreIn", 32'(coreIn), 32'(v));
      check("R7 safe chipOut", 32'(chipOut), 0);
      pulseCapture();
      shiftAll('0, outv);
      check("R5 captured outputs", 32'(outv[CH-1:IN_W]), 32'(coreModel(v[IN_W-1:0])));
      check("R4 input cells shifted out", 32'(outv[IN_W-1:0]), 32'(v));
      prevV = v[IN_W-1:0];
    end

    // R8: bypass with code 10 and code 11 (R2)
    for (int m = 2; m < 4; m++) begin
      setMode(m[1:0]);
      for (int k = 0; k < 24; k++) begin
        tamIn = ((k * 5 + m) % 3) == 0;
        chipIn = k[IN_W-1:0];
        @(negedge clk);
        check(m == 2 ? "R8 bypass lag" : "R2 code 11 bypass lag",
              32'(tamOut), 32'((((k * 5 + m) % 3) == 0) ? 1 : 0));
        check("R8 functional in bypass", 32'(coreIn), 32'(k % 16));
        check("R8 chipOut in bypass", 32'(chipOut), 32'(coreModel(k[IN_W-1:0])));
      end
    end

    setMode(2'b00);
    check("R3 tamOut back in functional", 32'(tamOut), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule